// File: doc/BRIEF.md
# Four-Lane Half-to-Single Float Expander

The block widens four packed half-precision floating-point values into four single-precision values at once. A 64-bit input word carries the four halves, with lane 0 in bits 15:0 and lane 3 in bits 63:48. Each half becomes a 32-bit value in the matching lane of a 128-bit output word, so lane 0 lands in bits 31:0. Every half-precision value has an exact single-precision equivalent, so the conversion never rounds.

Each lane picks one of three paths from its 5-bit exponent field alone. A field of zero selects the zero/subnormal path, a field of 31 selects the infinity/NaN path, and any other field selects the normal path. Subnormal halves are renormalized into normal singles rather than flushed to zero. NaN payload bits pass through unchanged. The result is registered. The output valid follows the input valid strobe one cycle later, and there is no backpressure.

Top module: `hf4_expand`

## Requirements
- R1: For a half with exponent field e in 1..30 and mantissa m, the lane output is {sign, e+112 (8 bits), m, 13 zero bits}.
- R2: For a half with exponent field 31, the lane output has exponent field 8'hFF and mantissa {m, 13 zero bits}. Infinity stays infinity and the NaN payload is kept without quieting.
- R3: For a half with exponent field 0 and nonzero mantissa m, the lane output is the normal single of the same magnitude, m·2^-24. Example: 16'h0001 gives 32'h33800000.
- R4: A half whose bits 14:0 are all zero gives a single whose bits 30:0 are all zero.
- R5: Output bit 31 of each lane equals input bit 15 of the same lane, for every encoding including zeros and NaNs.
- R6: Input lane i (bits 16i+15:16i) maps to output lane i (bits 32i+31:32i), for i = 0..3.
- R7: out_valid equals in_valid delayed by one clock. Data captured with in_valid high appears on out_word in that same next cycle.
- R8: While rst_n is low, out_valid is 0 and out_word is all zeros.
- R9: A cycle with in_valid low leaves out_word unchanged, whatever in_word carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word strobe |
| in_word | input | 64 | Four packed halves, lane 0 in bits 15:0 |
| out_valid | output | 1 | Output word strobe, one cycle after in_valid |
| out_word | output | 128 | Four singles, lane 0 in bits 31:0 |

## Verification
The bench drives every one of the 65536 half encodings through every lane. This covers every subnormal mantissa width, so a leading-zero count that is off by one shows up as an exponent or mantissa error of a factor of two. Negative zero must keep its sign; a zero path that drops bit 15 returns +0. NaNs with assorted payloads are checked bit-exact, so forcing quiet NaNs or clearing the payload is caught. A design that treated exponent 31 as a normal exponent would produce 143 instead of 255. Idle cycles carrying garbage input check that the output register holds, and a fixed four-value word catches swapped lanes.

// File: rtl/hf4_expand.sv
module hf4_expand #(
  parameter int LANES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [16*LANES-1:0] in_word,
  output logic                out_valid,
  output logic [32*LANES-1:0] out_word
);

  localparam int HW = 16;
  localparam int SW = 32;
  localparam logic [7:0] REBIAS = 8'd112;

  function automatic logic [SW-1:0] widen(input logic [HW-1:0] h);
    logic [4:0] lz;
    logic       seen;
    logic [9:0] frac;
    lz   = 5'd0;
    seen = 1'b0;
    for (int b = 9; b >= 0; b--) begin
      if (!seen) begin
        if (h[b]) seen = 1'b1;
        else      lz   = lz + 5'd1;
      end
    end
    frac = h[9:0] << (lz + 5'd1);
    if (h[14:10] == 5'h1f)
      widen = {h[15], 8'hff, h[9:0], 13'd0};
    else if (h[14:10] != 5'h00)
      widen = {h[15], {3'd0, h[14:10]} + REBIAS, h[9:0], 13'd0};
    else if (h[9:0] == 10'd0)
      widen = {h[15], 31'd0};
    else
      widen = {h[15], REBIAS - {3'd0, lz}, frac, 13'd0};
  endfunction

  logic [SW*LANES-1:0] conv;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign conv[SW*i +: SW] = widen(in_word[HW*i +: HW]);

    assert_sign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_word[SW*i+31] == $past(in_word[HW*i+15]));
    assert_special_exp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_word[HW*i+10 +: 5] == 5'h1f) |=> out_word[SW*i+23 +: 8] == 8'hff);
    assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_word[HW*i +: 15] == 15'd0) |=> out_word[SW*i +: 31] == 31'd0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_word <= conv;
    end
  end

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_word));

endmodule

// File: tb/hf4_expand_test.sv
`timescale 1ns/1ps
module hf4_expand_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [63:0]  in_word = '0;
  logic         out_valid;
  logic [127:0] out_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic         m_valid = 1'b0;
  logic [127:0] m_word = '0;
  logic [63:0]  m_src = '0;
  bit           m_held = 0;

  always #4 clk = ~clk;

  hf4_expand uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
                  .in_word(in_word), .out_valid(out_valid), .out_word(out_word));

  function automatic logic [31:0] ref_single(input logic [15:0] h);
    int e, mm, ee;
    e  = h[14:10];
    mm = h[9:0];
    if (e == 31) return {h[15], 8'hff, h[9:0], 13'd0};
    if (e == 0 && mm == 0) return {h[15], 31'd0};
    if (e == 0) begin
      ee = -14;
      while (mm < 1024) begin mm = mm * 2; ee = ee - 1; end
      mm = mm - 1024;
    end else ee = e - 15;
    return {h[15], 8'(ee + 127), 10'(mm), 13'd0};
  endfunction

  function automatic string tag_of(input logic [15:0] h);
    if (m_held) return "R9";
    if (h[14:10] == 5'h1f) return "R2";
    if (h[14:0] == 15'd0) return "R4/R5";
    if (h[14:10] == 5'h00) return "R3";
    return "R1";
  endfunction

  task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic compare_cycle();
    checks++;
    if (out_valid !== m_valid) begin
      errors++;
      $display("FAIL R7 out_valid got %b expected %b", out_valid, m_valid);
    end
    for (int i = 0; i < 4; i++) begin
      checks++;
      if (out_word[32*i +: 32] !== m_word[32*i +: 32]) begin
        errors++;
        $display("FAIL %s lane %0d in %h got %h expected %h", tag_of(m_src[16*i +: 16]), i,
                 m_src[16*i +: 16], out_word[32*i +: 32], m_word[32*i +: 32]);
      end
    end
  endtask

  task automatic drive(input logic v, input logic [63:0] w);
    in_valid = v;
    in_word  = w;
    m_valid  = v;
    m_held   = !v;
    if (v) begin
      m_src = w;
      for (int i = 0; i < 4; i++) m_word[32*i +: 32] = ref_single(w[16*i +: 16]);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    in_valid = 1'b1;
    in_word  = 64'h3c00_3c00_3c00_3c00;
    repeat (3) @(negedge clk);
    check("R8", {127'd0, out_valid}, 128'd0);
    check("R8", out_word, 128'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare_cycle();

    // R6: lanes 1.0, -2.0, +inf, smallest subnormal
    drive(1'b1, 64'h0001_7c00_c000_3c00);
    @(negedge clk);
    check("R6", out_word, 128'h33800000_7f800000_c0000000_3f800000);
    check("R7", {127'd0, out_valid}, 128'd1);
    compare_cycle();

    // R9: garbage while idle must not disturb output
    drive(1'b0, 64'hdead_beef_1234_5678);
    @(negedge clk);
    check("R9", out_word, 128'h33800000_7f800000_c0000000_3f800000);
    compare_cycle();

    // R4 R5: signed zeros, NaN payload R2
    drive(1'b1, 64'h8000_0000_fc01_7d55);
    @(negedge clk);
    check("R4", out_word, 128'h80000000_00000000_ff802000_7faaa000);
    compare_cycle();

    // Full sweep: every encoding in every lane (R1 R2 R3 R4 R5 R6)
    for (int k = 0; k < 65536; k++) begin
      logic [63:0] w;
      for (int i = 0; i < 4; i++) w[16*i +: 16] = 16'(k + i * 16411);
      if (k % 997 == 0) begin
        drive(1'b0, ~w);
        @(negedge clk);
        compare_cycle();
      end
      drive(1'b1, w);
      @(negedge clk);
      compare_cycle();
    end
    drive(1'b0, '0);
    @(negedge clk);
    compare_cycle();

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule